// File: doc/BRIEF.md
# Register-File Add Executor

This block carries out one 8-bit two's-complement add instruction against a 256-byte register file that it holds inside itself. A strobe on `start` begins an instruction. The block pulls the opcode and its operand bytes one at a time through a ready/valid style fetch handshake. It decodes one of five addressing modes and resolves the source operand, which can be a register, a register reached through a pointer register, or an immediate byte. It then writes the sum back into the destination register and updates a six-bit flag register.

Each opcode takes a fixed number of cycles when the byte stream never stalls. A one-cycle `done` pulse marks the end of the instruction. The register write and the new flags appear together with that pulse. If the fetch stream stalls, completion is pushed back until one edge after the last byte has been accepted. Opcodes outside the supported range change nothing. They raise `illegal` together with `done`. A combinational debug port reads any register at any time. Programs load values by adding immediates to registers, which reset to zero.

Top module: `add_exec`

## Requirements
- R1: The destination register receives (destination + source) mod 256. The source register keeps its value unless it is also the destination.
- R2: `flags` is {C,Z,S,V,D,H} on bits 5..0. C is the carry out of bit 7. Z is set when the 8-bit result is zero. S is the result's bit 7.
- R3: V is set only when both operands have equal bit 7 and the result's bit 7 differs from them.
- R4: D (bit 1) is always 0 after an add. H (bit 0) is the carry from bit 3 into bit 4.
- R5: Opcode 02h is two bytes. In the second byte, the high nibble selects the destination working register and the low nibble selects the source working register. Working register r is register-file address r. The instruction completes on the 4th edge.
- R6: Opcode 03h uses the same two-byte layout. The source working register holds the address of the operand. The instruction completes on the 6th edge.
- R7: Opcodes 04h, 05h and 06h are three bytes and complete on the 6th edge. For 04h, byte 2 is the source address and byte 3 is the destination. 05h is the same, but the source register holds the operand's address. For 06h, byte 2 is the destination and byte 3 is an immediate value.
- R8: `done` is high for exactly one cycle. It rises on the Nth rising edge after the edge that sampled `start`, where N is the opcode's cycle count, but never earlier than one edge after the last byte was accepted. The register write and the flag update take effect on that same edge.
- R9: Any opcode other than 02h–06h leaves the registers and flags unchanged. It raises `illegal` together with `done` on the 2nd edge.
- R10: `start` is ignored while an instruction is in progress.
- R11: `dbg_data` shows the register at `dbg_addr` combinationally. A write to that register is visible in the `done` cycle.
- R12: After reset, all registers and `flags` are zero, and `done`, `illegal` and `fetch_req` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an instruction when idle |
| fetch_req | output | 1 | Block wants the next instruction byte |
| fetch_valid | input | 1 | `fetch_byte` is valid; byte taken when both are high |
| fetch_byte | input | 8 | Instruction byte stream |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Unsupported opcode, pulses with `done` |
| flags | output | 6 | {C,Z,S,V,D,H} |
| dbg_addr | input | 8 | Debug read address |
| dbg_data | output | 8 | Register contents at `dbg_addr` |

## Verification
Two events meet on the completion edge: the destination write, and the `done` pulse with the flag update. On that same edge the debug port may be reading the very register being written. The bench points `dbg_addr` at each instruction's destination for the whole instruction. A behavioural model predicts, cycle by cycle, the old value before the `done` cycle and the new value from it onward, along with the flags and the pulse. Stalled fetches and a repeated `start` move or challenge that edge, and the same per-cycle comparison judges both cases.

// File: rtl/add_exec.sv
module add_exec #(
  parameter int AW = 8,
  parameter int WBASE = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          fetch_req,
  input  logic          fetch_valid,
  input  logic [7:0]    fetch_byte,
  output logic          done,
  output logic          illegal,
  output logic [5:0]    flags,
  input  logic [AW-1:0] dbg_addr,
  output logic [7:0]    dbg_data
);
  localparam int DEPTH = 1 << AW;

  logic [7:0]    rf [DEPTH];
  logic          busy;
  logic [2:0]    cnt;
  logic [1:0]    got, need;
  logic [2:0]    ncyc;
  logic [7:0]    opc, b1, b2;
  logic [AW-1:0] dst_a;
  logic [7:0]    src_v, dst_v;
  logic [8:0]    sum;
  logic [4:0]    lo;
  logic [5:0]    nflags;
  logic          legal, fin;

  function automatic logic [AW-1:0] wreg(input logic [3:0] r);
    return AW'(WBASE) + AW'(r);
  endfunction

  assign legal = (opc >= 8'h02) && (opc <= 8'h06);

  always_comb begin
    need = 2'd1;
    ncyc = 3'd2;
    if (got != 2'd0) begin
      case (opc)
        8'h02:                 begin need = 2'd2; ncyc = 3'd4; end
        8'h03:                 begin need = 2'd2; ncyc = 3'd6; end
        8'h04, 8'h05, 8'h06:   begin need = 2'd3; ncyc = 3'd6; end
        default:               begin need = 2'd1; ncyc = 3'd2; end
      endcase
    end
  end

  assign fetch_req = busy && (got < need);
  assign fin = busy && (got != 2'd0) && (got == need) && (cnt >= ncyc - 3'd1);

  always_comb begin
    dst_a = AW'(b1);
    src_v = 8'h00;
    case (opc)
      8'h02: begin dst_a = wreg(b1[7:4]); src_v = rf[wreg(b1[3:0])]; end
      8'h03: begin dst_a = wreg(b1[7:4]); src_v = rf[AW'(rf[wreg(b1[3:0])])]; end
      8'h04: begin dst_a = AW'(b2); src_v = rf[AW'(b1)]; end
      8'h05: begin dst_a = AW'(b2); src_v = rf[AW'(rf[AW'(b1)])]; end
      8'h06: begin dst_a = AW'(b1); src_v = b2; end
      default: ;
    endcase
  end

  assign dst_v  = rf[dst_a];
  assign sum    = {1'b0, dst_v} + {1'b0, src_v};
  assign lo     = {1'b0, dst_v[3:0]} + {1'b0, src_v[3:0]};
  assign nflags = {sum[8], sum[7:0] == 8'h00, sum[7],
                   (dst_v[7] == src_v[7]) && (sum[7] != dst_v[7]), 1'b0, lo[4]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      cnt     <= 3'd0;
      got     <= 2'd0;
      opc     <= 8'h00;
      b1      <= 8'h00;
      b2      <= 8'h00;
      done    <= 1'b0;
      illegal <= 1'b0;
      flags   <= 6'h00;
      for (int i = 0; i < DEPTH; i++) rf[i] <= 8'h00;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      if (!busy) begin
        if (start) begin
          busy <= 1'b1;
          cnt  <= 3'd0;
          got  <= 2'd0;
          opc  <= 8'h00;
        end
      end else begin
        if (cnt != 3'd7) cnt <= cnt + 3'd1;
        if (fetch_req && fetch_valid) begin
          case (got)
            2'd0:    opc <= fetch_byte;
            2'd1:    b1  <= fetch_byte;
            default: b2  <= fetch_byte;
          endcase
          got <= got + 2'd1;
        end
        if (fin) begin
          busy <= 1'b0;
          done <= 1'b1;
          if (legal) begin
            rf[dst_a] <= sum[7:0];
            flags     <= nflags;
          end else begin
            illegal <= 1'b1;
          end
        end
      end
    end
  end

  assign dbg_data = rf[dbg_addr];

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done);
  // R8
  fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) done |-> !fetch_req);
  // R9
  illegal_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> done);
  // R9
  illegal_flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) illegal |-> $stable(flags));
  // R10
  start_no_early_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> !done);
  // R4
  dflag_low_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> !flags[1]);
endmodule

// File: tb/add_exec_bench.sv
module add_exec_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic       fetch_req;
  logic       fetch_valid = 1'b0;
  logic [7:0] fetch_byte = 8'h00;
  logic       done, illegal;
  logic [5:0] flags;
  logic [7:0] dbg_addr = 8'h00;
  logic [7:0] dbg_data;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int mreg [256];
  logic [5:0] mflags = 6'h00;

  always #5 clk = ~clk;

  add_exec u_add_exec (
    .clk(clk), .rst_n(rst_n), .start(start), .fetch_req(fetch_req),
    .fetch_valid(fetch_valid), .fetch_byte(fetch_byte), .done(done),
    .illegal(illegal), .flags(flags), .dbg_addr(dbg_addr), .dbg_data(dbg_data)
  );

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input logic [7:0] o, input logic [7:0] a, input logic [7:0] b,
                     input int stall, input bit dbl, input string tag);
    logic [7:0] byt [3];
    int len, ncy, nexp, dst, sv, dv, s9, idx;
    bit bad, acc;
    logic [5:0] nf;
    byt[0] = o; byt[1] = a; byt[2] = b;
    bad = 1'b0; dst = 0; sv = 0;
    case (o)
      8'h02: begin len = 2; ncy = 4; dst = a[7:4]; sv = mreg[a[3:0]]; end
      8'h03: begin len = 2; ncy = 6; dst = a[7:4]; sv = mreg[mreg[a[3:0]]]; end
      8'h04: begin len = 3; ncy = 6; dst = b; sv = mreg[a]; end
      8'h05: begin len = 3; ncy = 6; dst = b; sv = mreg[mreg[a]]; end
      8'h06: begin len = 3; ncy = 6; dst = a; sv = b; end
      default: begin len = 1; ncy = 2; bad = 1'b1; end
    endcase
    nexp = (stall + len + 1 > ncy) ? stall + len + 1 : ncy;
    dv = mreg[dst];
    s9 = dv + sv;
    nf = bad ? mflags :
         {s9 > 255, (s9 & 255) == 0, s9[7], (dv[7] == sv[7]) && (s9[7] != dv[7]),
          1'b0, ((dv & 15) + (sv & 15)) > 15};
    dbg_addr = 8'(dst);
    @(negedge clk);
    start = 1'b1;
    @(posedge clk);
    idx = 0;
    for (int k = 1; k <= nexp + 2; k++) begin
      @(negedge clk);
      start = dbl && (k == 2);
      fetch_valid = (k > stall) && (idx < len);
      fetch_byte = (idx < len) ? byt[idx] : 8'h00;
      chk(done, k == nexp + 1, "R8");
      chk(illegal, bad && (k == nexp + 1), "R9");
      chk(flags, (k >= nexp + 1) ? nf : mflags, tag);
      chk(dbg_data, (k >= nexp + 1 && !bad) ? (s9 & 255) : dv, "R11");
      acc = fetch_req && fetch_valid;
      @(posedge clk);
      if (acc) idx++;
    end
    @(negedge clk);
    fetch_valid = 1'b0;
    start = 1'b0;
    if (!bad) begin
      mreg[dst] = s9 & 255;
      mflags = nf;
    end
  endtask

  task automatic peek(input int addr, input string tag);
    dbg_addr = 8'(addr);
    #1;
    chk(dbg_data, mreg[addr], tag);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mreg[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R12 reset state
    chk(flags, 0, "R12");
    chk(done, 0, "R12");
    chk(illegal, 0, "R12");
    chk(fetch_req, 0, "R12");
    peek(8'h01, "R12");
    peek(8'hFF, "R12");

    run(8'h06, 8'h01, 8'h21, 0, 0, "R7");
    run(8'h06, 8'h02, 8'h03, 0, 0, "R7");
    run(8'h06, 8'h03, 8'h0A, 0, 0, "R7");
    run(8'h06, 8'h0A, 8'h55, 0, 0, "R7");
    run(8'h05, 8'h02, 8'h01, 0, 0, "R7");
    peek(8'h01, "R7");
    run(8'h04, 8'h02, 8'h01, 0, 0, "R1");
    peek(8'h02, "R1");
    run(8'h02, 8'h12, 8'h00, 0, 0, "R5");
    chk(flags[0], 1, "R4");
    peek(8'h02, "R5");
    run(8'h03, 8'h13, 8'h00, 0, 0, "R6");
    chk(flags[2], 1, "R3");
    chk(flags[3], 1, "R2");
    run(8'h06, 8'h20, 8'h80, 0, 0, "R2");
    run(8'h06, 8'h20, 8'h80, 0, 0, "R3");
    chk(flags, 6'b110100, "R3");
    run(8'h06, 8'h21, 8'hFF, 0, 0, "R4");
    run(8'h06, 8'h21, 8'h01, 0, 0, "R4");
    chk(flags, 6'b110001, "R4");
    chk(flags[1], 0, "R4");
    run(8'h07, 8'h00, 8'h00, 0, 0, "R9");
    run(8'h00, 8'h00, 8'h00, 0, 0, "R9");
    run(8'h06, 8'h30, 8'h44, 0, 0, "R7");
    run(8'h04, 8'h30, 8'h31, 3, 0, "R8");
    run(8'h02, 8'h45, 8'h00, 2, 0, "R8");
    run(8'h06, 8'h31, 8'h7F, 0, 1, "R10");
    peek(8'h31, "R10");
    run(8'h05, 8'h03, 8'h03, 1, 1, "R10");
    peek(8'h03, "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule